// File: doc/BRIEF.md
# Compact RV64 Subset Processor Core

A multi-cycle processor core that runs a fourteen-instruction slice of the 64-bit RISC-V integer ISA. The slice covers upper-immediate load, add-immediate, doubleword load and store, add, subtract, multiply, unsigned divide, unsigned remainder, unsigned set-less-than, branch-if-equal, jump-and-link, jump-and-link-register, and the environment call. The core holds a 64-bit program counter and thirty-two 64-bit general registers, where register 0 always reads zero.

Instructions and data share one memory port. The port is 64 bits wide and addresses doublewords. The core raises a request and holds it steady until the memory answers with a one-cycle valid pulse. Each instruction is fetched as a doubleword, and bit 2 of the program counter picks which 32-bit half to run. An environment call puts the call number (x17) and three arguments (x10 to x12) on a handshake port and waits for an acknowledge. It then writes the returned value into x10. If an opcode falls outside the slice, or a load or store address is not a multiple of eight, the core raises a sticky flag and stops.

Top module: `mini_rv_core`

## Requirements
- R1: While reset is held and right after it is released, the core requests an instruction fetch at doubleword index RESET_PC>>3, with the write enable low and both fault flags low.
- R2: Register x0 reads as zero, and any write to it is discarded.
- R3: The upper-immediate load writes its sign-extended 20-bit immediate shifted left by 12. The add-immediate adds a sign-extended 12-bit immediate to rs1.
- R4: Add and subtract wrap modulo 2^64. Multiply keeps the low 64 bits of the product.
- R5: Set-less-than, divide and remainder treat both operands as unsigned 64-bit values. Set-less-than writes 1 or 0.
- R6: Dividing by zero gives all ones as the quotient, and the dividend as the remainder.
- R7: Load and store move one whole doubleword at index (rs1 + sign-extended imm12) >> 3. The word at a byte address with bit 2 clear is bits 31:0 of its doubleword, and with bit 2 set it is bits 63:32.
- R8: A load or store whose effective address has a nonzero low three bits sets alignFault. The core then halts: it makes no memory access, writes no register, and raises no system request.
- R9: A taken branch-if-equal moves pc by its 13-bit immediate, and a branch that is not taken moves pc by 4. Jump-and-link writes pc+4 and moves pc by its 21-bit immediate. Jump-and-link-register writes pc+4 and jumps to (rs1+imm) with bit 0 cleared.
- R10: The environment call (word 0x00000073) holds sysReq, with x17, x10, x11 and x12 on sysNum and sysArg0 to sysArg2, steady until sysAck. It then writes sysRet into x10 and continues at pc+4.
- R11: Any encoding outside the fourteen instructions sets illegalInstr. After that the core makes no more memory or system requests until reset. For example, a register-register shift, or a load whose funct3 is not 011, counts as outside.
- R12: A memory request keeps its address, write enable and write data steady until memValid arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| memReq | output | 1 | Memory request, held until memValid |
| memWe | output | 1 | Request is a store |
| memAddr | output | ADDR_W | Doubleword index |
| memWdata | output | XLEN | Store data |
| memValid | input | 1 | One-cycle response pulse |
| memRdata | input | XLEN | Read data, valid with memValid |
| sysReq | output | 1 | System call pending |
| sysNum | output | XLEN | Call number (x17) |
| sysArg0 | output | XLEN | Argument x10 |
| sysArg1 | output | XLEN | Argument x11 |
| sysArg2 | output | XLEN | Argument x12 |
| sysAck | input | 1 | System call answered |
| sysRet | input | XLEN | Value returned into x10 |
| illegalInstr | output | 1 | Sticky illegal-encoding flag |
| alignFault | output | 1 | Sticky misaligned-access flag |

## Verification
The bench builds the core with XLEN left at 64, ADDR_W set to 8 and RESET_PC set to 0x100. A 256-doubleword memory model then covers the code area and the data area at 0x1F8 to 0x210. With a nonzero reset vector, the first-fetch check can tell the vector apart from address zero. Keeping XLEN at 64 means the full-width carry and borrow cases are checked: the multiply overflow, the unsigned divide of all ones, and the 64-step divide-by-zero. The memory model's response latency can be raised, and the call acknowledge can be delayed, so that held requests are observed.

// File: rtl/mini_rv_pkg.sv
`timescale 1ns/1ps
package mini_rv_pkg;

  typedef enum logic [2:0] {ALU_ADD, ALU_SUB, ALU_MUL, ALU_SLTU, ALU_PASSB} aluOpE;
  typedef enum logic [2:0] {IMM_I, IMM_S, IMM_B, IMM_U, IMM_J} immSelE;
  typedef enum logic [2:0] {WB_ALU, WB_MEM, WB_LINK, WB_SYS, WB_QUO, WB_REM} wbSelE;
  typedef enum logic [1:0] {PC_KEEP, PC_NEXT, PC_REL, PC_ABS} pcSelE;

  typedef enum logic [3:0] {
    K_LUI, K_ADDI, K_LD, K_SD, K_ADD, K_SUB, K_MUL,
    K_DIVU, K_REMU, K_SLTU, K_BEQ, K_JAL, K_JALR, K_ECALL, K_BAD
  } instrKindE;

  // Strobes the control FSM hands to the datapath each cycle.
  typedef struct packed {
    logic   irLoad;
    logic   regWe;
    logic   toA0;
    wbSelE  wbSel;
    pcSelE  pcSel;
    aluOpE  aluOp;
    immSelE immSel;
    logic   useImm;
    logic   addrEa;
    logic   divStart;
  } strobesT;

endpackage

// File: rtl/mini_rv_datapath.sv
`timescale 1ns/1ps
module mini_rv_datapath
  import mini_rv_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int ADDR_W = 29,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobesT           ctl,
  input  logic [XLEN-1:0]   memRdata,
  input  logic [XLEN-1:0]   sysRet,
  output logic [31:0]       ir,
  output logic              rsEq,
  output logic [2:0]        eaLow3,
  output logic              divBusy,
  output logic [ADDR_W-1:0] memAddr,
  output logic [XLEN-1:0]   memWdata,
  output logic [XLEN-1:0]   sysNum,
  output logic [XLEN-1:0]   sysArg0,
  output logic [XLEN-1:0]   sysArg1,
  output logic [XLEN-1:0]   sysArg2
);
  localparam int NREG  = 32;
  localparam int CNT_W = $clog2(XLEN + 1);

  logic [XLEN-1:0]  pc, rs1V, rs2V, imm, opB, aluRes, wbData, quo, rem;
  logic [XLEN-1:0]  regs [NREG];
  logic [XLEN:0]    remShift;
  logic [CNT_W-1:0] divCnt;
  logic [4:0]       wbAddr;

  assign rs1V = (ir[19:15] == 5'd0) ? '0 : regs[ir[19:15]];
  assign rs2V = (ir[24:20] == 5'd0) ? '0 : regs[ir[24:20]];

  always_comb begin
    case (ctl.immSel)
      IMM_S:   imm = {{(XLEN-12){ir[31]}}, ir[31:25], ir[11:7]};
      IMM_B:   imm = {{(XLEN-13){ir[31]}}, ir[31], ir[7], ir[30:25], ir[11:8], 1'b0};
      IMM_U:   imm = {{(XLEN-32){ir[31]}}, ir[31:12], 12'b0};
      IMM_J:   imm = {{(XLEN-21){ir[31]}}, ir[31], ir[19:12], ir[20], ir[30:21], 1'b0};
      default: imm = {{(XLEN-12){ir[31]}}, ir[31:20]};
    endcase
  end

  assign opB = ctl.useImm ? imm : rs2V;

  always_comb begin
    case (ctl.aluOp)
      ALU_SUB:   aluRes = rs1V - opB;
      ALU_MUL:   aluRes = rs1V * opB;
      ALU_SLTU:  aluRes = XLEN'(rs1V < opB);
      ALU_PASSB: aluRes = opB;
      default:   aluRes = rs1V + opB;
    endcase
  end

  always_comb begin
    case (ctl.wbSel)
      WB_MEM:  wbData = memRdata;
      WB_LINK: wbData = pc + XLEN'(4);
      WB_SYS:  wbData = sysRet;
      WB_QUO:  wbData = quo;
      WB_REM:  wbData = rem;
      default: wbData = aluRes;
    endcase
  end

  assign wbAddr   = ctl.toA0 ? 5'd10 : ir[11:7];
  assign remShift = {rem, quo[XLEN-1]};
  assign divBusy  = (divCnt != '0);
  assign rsEq     = (rs1V == rs2V);
  assign eaLow3   = aluRes[2:0];
  assign memAddr  = ctl.addrEa ? aluRes[ADDR_W+2:3] : pc[ADDR_W+2:3];
  assign memWdata = rs2V;
  assign sysNum   = regs[17];
  assign sysArg0  = regs[10];
  assign sysArg1  = regs[11];
  assign sysArg2  = regs[12];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc     <= RESET_PC;
      ir     <= '0;
      quo    <= '0;
      rem    <= '0;
      divCnt <= '0;
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      if (ctl.irLoad) ir <= pc[2] ? memRdata[63:32] : memRdata[31:0];
      if (ctl.regWe && wbAddr != 5'd0) regs[wbAddr] <= wbData;
      case (ctl.pcSel)
        PC_NEXT: pc <= pc + XLEN'(4);
        PC_REL:  pc <= pc + imm;
        PC_ABS:  pc <= {aluRes[XLEN-1:1], 1'b0};
        default: ;
      endcase
      // Restoring divider, one quotient bit per cycle
      if (ctl.divStart) begin
        quo    <= rs1V;
        rem    <= '0;
        divCnt <= CNT_W'(XLEN);
      end else if (divBusy) begin
        if (remShift >= {1'b0, rs2V}) begin
          rem <= XLEN'(remShift - {1'b0, rs2V});
          quo <= {quo[XLEN-2:0], 1'b1};
        end else begin
          rem <= remShift[XLEN-1:0];
          quo <= {quo[XLEN-2:0], 1'b0};
        end
        divCnt <= divCnt - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/mini_rv_ctrl.sv
`timescale 1ns/1ps
module mini_rv_ctrl
  import mini_rv_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] ir,
  input  logic        rsEq,
  input  logic [2:0]  eaLow3,
  input  logic        divBusy,
  input  logic        memValid,
  input  logic        sysAck,
  output strobesT     ctl,
  output logic        memReq,
  output logic        memWe,
  output logic        sysReq,
  output logic        illegalInstr,
  output logic        alignFault
);
  typedef enum logic [2:0] {S_FETCH, S_EXEC, S_MEM, S_DIV, S_SYS, S_HALT} stateE;
  stateE state, stateN;
  instrKindE kind;

  always_comb begin
    kind = K_BAD;
    case (ir[6:0])
      7'b0110111: kind = K_LUI;
      7'b1101111: kind = K_JAL;
      7'b0010011: if (ir[14:12] == 3'b000) kind = K_ADDI;
      7'b0000011: if (ir[14:12] == 3'b011) kind = K_LD;
      7'b0100011: if (ir[14:12] == 3'b011) kind = K_SD;
      7'b1100011: if (ir[14:12] == 3'b000) kind = K_BEQ;
      7'b1100111: if (ir[14:12] == 3'b000) kind = K_JALR;
      7'b1110011: if (ir == 32'h0000_0073) kind = K_ECALL;
      7'b0110011:
        case ({ir[31:25], ir[14:12]})
          {7'h00, 3'b000}: kind = K_ADD;
          {7'h20, 3'b000}: kind = K_SUB;
          {7'h01, 3'b000}: kind = K_MUL;
          {7'h01, 3'b101}: kind = K_DIVU;
          {7'h01, 3'b111}: kind = K_REMU;
          {7'h00, 3'b011}: kind = K_SLTU;
          default: ;
        endcase
      default: ;
    endcase
  end

  always_comb begin
    ctl = '0;
    memReq = 1'b0;
    memWe  = 1'b0;
    sysReq = 1'b0;
    stateN = state;
    ctl.aluOp  = ALU_ADD;
    ctl.immSel = IMM_I;
    case (kind)
      K_LUI:  begin ctl.aluOp = ALU_PASSB; ctl.immSel = IMM_U; ctl.useImm = 1'b1; end
      K_ADDI, K_LD, K_JALR: ctl.useImm = 1'b1;
      K_SD:   begin ctl.immSel = IMM_S; ctl.useImm = 1'b1; end
      K_SUB:  ctl.aluOp = ALU_SUB;
      K_MUL:  ctl.aluOp = ALU_MUL;
      K_SLTU: ctl.aluOp = ALU_SLTU;
      K_BEQ:  ctl.immSel = IMM_B;
      K_JAL:  ctl.immSel = IMM_J;
      default: ;
    endcase
    case (state)
      S_FETCH: begin
        memReq = 1'b1;
        if (memValid) begin ctl.irLoad = 1'b1; stateN = S_EXEC; end
      end
      S_EXEC: begin
        stateN = S_FETCH;
        case (kind)
          K_BAD:        stateN = S_HALT;
          K_LD, K_SD:   stateN = (eaLow3 != 3'd0) ? S_HALT : S_MEM;
          K_DIVU, K_REMU: begin ctl.divStart = 1'b1; stateN = S_DIV; end
          K_ECALL:      stateN = S_SYS;
          K_BEQ:        ctl.pcSel = rsEq ? PC_REL : PC_NEXT;
          K_JAL:  begin ctl.regWe = 1'b1; ctl.wbSel = WB_LINK; ctl.pcSel = PC_REL; end
          K_JALR: begin ctl.regWe = 1'b1; ctl.wbSel = WB_LINK; ctl.pcSel = PC_ABS; end
          default: begin ctl.regWe = 1'b1; ctl.wbSel = WB_ALU; ctl.pcSel = PC_NEXT; end
        endcase
      end
      S_MEM: begin
        memReq = 1'b1;
        memWe  = (kind == K_SD);
        ctl.addrEa = 1'b1;
        if (memValid) begin
          ctl.regWe = (kind == K_LD);
          ctl.wbSel = WB_MEM;
          ctl.pcSel = PC_NEXT;
          stateN = S_FETCH;
        end
      end
      S_DIV: if (!divBusy) begin
        ctl.regWe = 1'b1;
        ctl.wbSel = (kind == K_DIVU) ? WB_QUO : WB_REM;
        ctl.pcSel = PC_NEXT;
        stateN = S_FETCH;
      end
      S_SYS: begin
        sysReq = 1'b1;
        if (sysAck) begin
          ctl.regWe = 1'b1;
          ctl.toA0  = 1'b1;
          ctl.wbSel = WB_SYS;
          ctl.pcSel = PC_NEXT;
          stateN = S_FETCH;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= S_FETCH;
      illegalInstr <= 1'b0;
      alignFault   <= 1'b0;
    end else begin
      state <= stateN;
      if (state == S_EXEC) begin
        if (kind == K_BAD) illegalInstr <= 1'b1;
        if ((kind == K_LD || kind == K_SD) && eaLow3 != 3'd0) alignFault <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/mini_rv_core.sv
`timescale 1ns/1ps
module mini_rv_core
  import mini_rv_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int ADDR_W = 29,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rstN,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [XLEN-1:0]   memWdata,
  input  logic              memValid,
  input  logic [XLEN-1:0]   memRdata,
  output logic              sysReq,
  output logic [XLEN-1:0]   sysNum,
  output logic [XLEN-1:0]   sysArg0,
  output logic [XLEN-1:0]   sysArg1,
  output logic [XLEN-1:0]   sysArg2,
  input  logic              sysAck,
  input  logic [XLEN-1:0]   sysRet,
  output logic              illegalInstr,
  output logic              alignFault
);
  strobesT     ctl;
  logic [31:0] ir;
  logic        rsEq, divBusy;
  logic [2:0]  eaLow3;

  mini_rv_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ir(ir), .rsEq(rsEq), .eaLow3(eaLow3),
    .divBusy(divBusy), .memValid(memValid), .sysAck(sysAck), .ctl(ctl),
    .memReq(memReq), .memWe(memWe), .sysReq(sysReq),
    .illegalInstr(illegalInstr), .alignFault(alignFault)
  );

  mini_rv_datapath #(.XLEN(XLEN), .ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .memRdata(memRdata), .sysRet(sysRet),
    .ir(ir), .rsEq(rsEq), .eaLow3(eaLow3), .divBusy(divBusy),
    .memAddr(memAddr), .memWdata(memWdata), .sysNum(sysNum),
    .sysArg0(sysArg0), .sysArg1(sysArg1), .sysArg2(sysArg2)
  );
endmodule

// File: rtl/mini_rv_checks.sv
`timescale 1ns/1ps
module mini_rv_checks #(
  parameter int XLEN = 64,
  parameter int ADDR_W = 29
) (
  input logic              clk,
  input logic              rstN,
  input logic              memReq,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [XLEN-1:0]   memWdata,
  input logic              memValid,
  input logic              sysReq,
  input logic [XLEN-1:0]   sysNum,
  input logic [XLEN-1:0]   sysArg0,
  input logic              sysAck,
  input logic              illegalInstr,
  input logic              alignFault
);
  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memValid |=> memReq && $stable(memAddr) && $stable(memWe) && $stable(memWdata));

  p_sys_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    sysReq && !sysAck |=> sysReq && $stable(sysNum) && $stable(sysArg0));

  p_port_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(memReq && sysReq));

  p_illegal_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    illegalInstr |-> !memReq && !sysReq);

  p_illegal_sticky_r11: assert property (@(posedge clk) disable iff (!rstN)
    illegalInstr |=> illegalInstr);

  p_align_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    alignFault |-> !memReq && !sysReq);

  p_align_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    alignFault |=> alignFault);

  p_single_fault_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(alignFault && illegalInstr));
endmodule

bind mini_rv_core mini_rv_checks #(.XLEN(XLEN), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
  .memWdata(memWdata), .memValid(memValid), .sysReq(sysReq), .sysNum(sysNum),
  .sysArg0(sysArg0), .sysAck(sysAck), .illegalInstr(illegalInstr),
  .alignFault(alignFault)
);

// File: tb/mini_rv_core_tb.sv
`timescale 1ns/1ps
module mini_rv_core_tb;
  localparam int XLEN = 64;
  localparam int ADDR_W = 8;
  localparam logic [63:0] RST_PC = 64'h100;
  localparam logic [63:0] ONES = {64{1'b1}};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic memReq, memWe, memValid = 1'b0;
  logic [ADDR_W-1:0] memAddr;
  logic [63:0] memWdata, memRdata = '0;
  logic sysReq, sysAck = 1'b0, illegalInstr, alignFault;
  logic [63:0] sysNum, sysArg0, sysArg1, sysArg2, sysRet = '0;

  logic [63:0] mem [256];
  int memDelay = 0;
  int waitCnt = 0;
  int nChecks = 0;
  int nFail = 0;
  logic [63:0] emitPc;
  bit sysSeen;

  always #5 clk = ~clk;

  mini_rv_core #(.XLEN(XLEN), .ADDR_W(ADDR_W), .RESET_PC(RST_PC)) u_dut (
    .clk(clk), .rstN(rstN), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memValid(memValid), .memRdata(memRdata),
    .sysReq(sysReq), .sysNum(sysNum), .sysArg0(sysArg0), .sysArg1(sysArg1),
    .sysArg2(sysArg2), .sysAck(sysAck), .sysRet(sysRet),
    .illegalInstr(illegalInstr), .alignFault(alignFault)
  );

  // Memory model with programmable response latency
  always @(posedge clk) begin
    if (!rstN) begin
      memValid <= 1'b0;
      waitCnt  <= 0;
    end else begin
      memValid <= 1'b0;
      if (memReq && !memValid) begin
        if (waitCnt >= memDelay) begin
          memValid <= 1'b1;
          waitCnt  <= 0;
          memRdata <= mem[memAddr];
          if (memWe) mem[memAddr] <= memWdata;
        end else waitCnt <= waitCnt + 1;
      end
    end
  end

  always @(posedge clk) if (rstN && sysReq) sysSeen = 1'b1;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Encoders
  function automatic logic [31:0] iType(logic [11:0] imm, logic [4:0] rs1, logic [2:0] f3, logic [4:0] rd, logic [6:0] op);
    return {imm, rs1, f3, rd, op};
  endfunction
  function automatic logic [31:0] addi(logic [4:0] rd, logic [4:0] rs1, logic [11:0] imm);
    return iType(imm, rs1, 3'b000, rd, 7'b0010011);
  endfunction
  function automatic logic [31:0] ld(logic [4:0] rd, logic [4:0] rs1, logic [11:0] imm);
    return iType(imm, rs1, 3'b011, rd, 7'b0000011);
  endfunction
  function automatic logic [31:0] jalr(logic [4:0] rd, logic [4:0] rs1, logic [11:0] imm);
    return iType(imm, rs1, 3'b000, rd, 7'b1100111);
  endfunction
  function automatic logic [31:0] sd(logic [4:0] rs2, logic [4:0] rs1, logic [11:0] imm);
    return {imm[11:5], rs2, rs1, 3'b011, imm[4:0], 7'b0100011};
  endfunction
  function automatic logic [31:0] rType(logic [6:0] f7, logic [2:0] f3, logic [4:0] rd, logic [4:0] rs1, logic [4:0] rs2);
    return {f7, rs2, rs1, f3, rd, 7'b0110011};
  endfunction
  function automatic logic [31:0] lui(logic [4:0] rd, logic [19:0] imm);
    return {imm, rd, 7'b0110111};
  endfunction
  function automatic logic [31:0] beq(logic [4:0] rs1, logic [4:0] rs2, logic [12:0] imm);
    return {imm[12], imm[10:5], rs2, rs1, 3'b000, imm[4:1], imm[11], 7'b1100011};
  endfunction
  function automatic logic [31:0] jal(logic [4:0] rd, logic [20:0] imm);
    return {imm[20], imm[10:1], imm[11], imm[19:12], rd, 7'b1101111};
  endfunction
  localparam logic [31:0] ECALL = 32'h0000_0073;

  task automatic emit(logic [31:0] w);
    if (emitPc[2]) mem[emitPc[10:3]][63:32] = w;
    else           mem[emitPc[10:3]][31:0]  = w;
    emitPc = emitPc + 4;
  endtask

  task automatic clearMem();
    for (int i = 0; i < 256; i++) mem[i] = '0;
    emitPc = RST_PC;
    sysSeen = 1'b0;
  endtask

  task automatic startCore();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic expectSys(string tag, logic [63:0] num, logic [63:0] a0, logic [63:0] a1,
                           logic [63:0] a2, logic [63:0] ret, int ackDelay);
    int n = 0;
    @(negedge clk);
    while (!sysReq && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk({tag, " sysReq"}, 64'(sysReq), 64'd1);
    chk({tag, " num"}, sysNum, num);
    chk({tag, " a0"}, sysArg0, a0);
    chk({tag, " a1"}, sysArg1, a1);
    chk({tag, " a2"}, sysArg2, a2);
    for (int k = 0; k < ackDelay; k++) begin
      @(negedge clk);
      chk({tag, " R10 held"}, {sysNum[62:0], sysReq}, {num[62:0], 1'b1});
    end
    sysAck = 1'b1;
    sysRet = ret;
    @(negedge clk);
    sysAck = 1'b0;
  endtask

  task automatic testReset();
    clearMem();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 req in reset", 64'(memReq), 64'd1);
    rstN = 1'b1;
    #1;
    chk("R1 fetch addr", 64'(memAddr), RST_PC >> 3);
    chk("R1 we", 64'(memWe), 64'd0);
    chk("R1 faults", {62'd0, illegalInstr, alignFault}, 64'd0);
  endtask

  task automatic testInit();
    clearMem();
    emit(addi(10, 0, 12'hFFF));
    emit(lui(11, 20'h80000));
    emit(addi(12, 0, 12'h7FF));
    emit(addi(0, 0, 12'd5));
    emit(rType(7'h00, 3'b000, 17, 0, 0));
    emit(ECALL);
    emit(addi(17, 0, 12'd1));
    emit(addi(11, 10, 12'd0));
    emit(ECALL);
    startCore();
    expectSys("R3 R2 init", 64'd0, ONES, 64'hFFFF_FFFF_8000_0000, 64'd2047, 64'h1234, 4);
    expectSys("R10 ret", 64'd1, 64'h1234, 64'h1234, 64'd2047, 64'd0, 0);
  endtask

  task automatic testWrap();
    clearMem();
    emit(addi(5, 0, 12'hFFF));
    emit(addi(6, 0, 12'd1));
    emit(rType(7'h00, 3'b000, 10, 5, 6));
    emit(rType(7'h20, 3'b000, 11, 0, 6));
    emit(rType(7'h01, 3'b000, 12, 5, 5));
    emit(addi(17, 0, 12'd2));
    emit(ECALL);
    startCore();
    expectSys("R4 wrap", 64'd2, 64'd0, ONES, 64'd1, 64'd0, 0);
  endtask

  task automatic testUnsigned();
    logic [63:0] q, r;
    q = ONES / 64'd7;
    r = ONES % 64'd7;
    clearMem();
    emit(addi(5, 0, 12'hFFF));
    emit(addi(6, 0, 12'd7));
    emit(rType(7'h00, 3'b011, 10, 6, 5));
    emit(rType(7'h01, 3'b101, 11, 5, 6));
    emit(rType(7'h01, 3'b111, 12, 5, 6));
    emit(addi(17, 0, 12'd3));
    emit(ECALL);
    emit(rType(7'h01, 3'b101, 10, 6, 0));
    emit(rType(7'h01, 3'b111, 11, 6, 0));
    emit(rType(7'h00, 3'b011, 12, 5, 6));
    emit(addi(17, 0, 12'd4));
    emit(ECALL);
    startCore();
    expectSys("R5 unsigned", 64'd3, 64'd1, q, r, 64'd0, 0);
    expectSys("R6 div zero", 64'd4, ONES, 64'd7, 64'd0, 64'd0, 0);
  endtask

  task automatic testMemory(int delay, string tag);
    clearMem();
    memDelay = delay;
    mem[8'h41] = 64'hDEAD_BEEF_CAFE_F00D;
    emit(addi(5, 0, 12'h200));
    emit(ld(10, 5, 12'd8));
    emit(sd(10, 5, 12'd16));
    emit(addi(6, 0, 12'hFFF));
    emit(sd(6, 5, 12'hFF8));
    emit(ld(11, 5, 12'hFF8));
    emit(addi(17, 0, 12'd5));
    emit(ECALL);
    startCore();
    expectSys({tag, " ld"}, 64'd5, 64'hDEAD_BEEF_CAFE_F00D, ONES, 64'd0, 64'd0, 0);
    chk({tag, " sd +16"}, mem[8'h42], 64'hDEAD_BEEF_CAFE_F00D);
    chk({tag, " sd -8"}, mem[8'h3F], ONES);
    memDelay = 0;
  endtask

  task automatic testControl();
    clearMem();
    emit(addi(10, 0, 12'd0));
    emit(beq(0, 0, 13'd8));
    emit(addi(10, 10, 12'd1));
    emit(addi(6, 0, 12'd1));
    emit(beq(6, 0, 13'd8));
    emit(addi(10, 10, 12'd2));
    emit(jal(11, 21'd8));
    emit(addi(10, 10, 12'd4));
    emit(addi(7, 0, 12'h130));
    emit(jalr(12, 7, 12'd1));
    emit(addi(10, 10, 12'd8));
    emit(addi(10, 10, 12'd8));
    emit(addi(17, 0, 12'd6));
    emit(ECALL);
    startCore();
    expectSys("R9 branch", 64'd6, 64'd2, 64'h11C, 64'h128, 64'd0, 0);
  endtask

  task automatic testMisaligned();
    clearMem();
    mem[8'h40] = 64'h5555;
    emit(addi(5, 0, 12'h204));
    emit(addi(10, 0, 12'd9));
    emit(sd(10, 5, 12'd0));
    emit(ECALL);
    startCore();
    repeat (40) @(negedge clk);
    chk("R8 fault", {62'd0, illegalInstr, alignFault}, 64'd1);
    chk("R8 quiet", {62'd0, memReq, sysSeen}, 64'd0);
    chk("R8 no store", mem[8'h40], 64'h5555);
  endtask

  task automatic testIllegal(logic [31:0] bad, string tag);
    clearMem();
    emit(addi(5, 0, 12'd1));
    emit(bad);
    emit(ECALL);
    startCore();
    repeat (40) @(negedge clk);
    chk({tag, " flag"}, {62'd0, illegalInstr, alignFault}, 64'd2);
    chk({tag, " quiet"}, {62'd0, memReq, sysSeen}, 64'd0);
  endtask

  initial begin
    #2_000_000;
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    testReset();
    testInit();
    testWrap();
    testUnsigned();
    testMemory(0, "R7");
    testMemory(3, "R12 slow");
    testControl();
    testMisaligned();
    testIllegal(32'h0000_1033, "R11 shift");
    testIllegal(32'h0000_2003, "R11 word load");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule